// File: doc/BRIEF.md
# Branch Resolution and Delay-Slot Next-PC Unit

This unit owns the program counter of a 32-bit core whose instructions are all 4 bytes long. In every cycle where `issue_en` is high, the instruction at `fetch_pc` issues. Its decoded control-transfer kind, its two source operands, its 16-bit displacement and its 26-bit jump field arrive in that same cycle. The unit decides whether control transfers. The decision is an equality test between the two operands, a sign or zero test on the first operand, or unconditional for jumps. It then forms the destination, which is one of three: relative to the following instruction, inside the current 256 MB region, or taken from a register. For call forms it also raises a write of the return address to register 31.

A transfer never takes effect at once. The instruction right after a branch or jump, which is the delay slot, always issues next. The redirect is held pending and is applied when that slot instruction issues. If the slot instruction is itself a taken transfer, its own redirect is held in turn and applied one instruction later.

Top module: `branch_pc_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` is `RESET_PC` (default 0x0000_1000), and `taken` and `link_we` are 0 whatever the other inputs are.
- R2: An issuing instruction that is not a transfer, and that is not executed as a delay slot, moves `fetch_pc` to `fetch_pc + 4` at the next clock. Kind codes 0 and 12 to 15 mean "no transfer".
- R3: Kind 1 is taken when `src_a == src_b`, and kind 2 is taken when they differ.
- R4: The sign tests on `src_a` as a signed value are kind 3 (`<= 0`), kind 4 (`> 0`), kind 5 (`< 0`), kind 6 (`>= 0`), kind 7 (`< 0`, with link) and kind 8 (`>= 0`, with link).
- R5: The destination of a taken branch (kinds 1 to 8) is `fetch_pc + 4 + (sign-extended br_off << 2)`, computed modulo 2^32.
- R6: Kinds 9 (jump), 10 (jump with link) and 11 (jump to register) are always taken. Kinds 9 and 10 go to `{(fetch_pc+4)[31:28], jmp_field, 2'b00}`. Kind 11 goes to `src_a`.
- R7: Kinds 7, 8 and 10 raise `link_we` in their issue cycle, whether or not the transfer is taken, with `link_val = fetch_pc + 8`. No other kind raises `link_we`.
- R8: After a taken transfer at address P, the next instruction fetched is P+4 (the delay slot). When that slot instruction issues, `fetch_pc` moves to the held destination.
- R9: While `issue_en` is low, `fetch_pc` and any held redirect stay unchanged, and `taken` and `link_we` are 0.
- R10: A taken transfer inside a delay slot is honoured one instruction late. The held redirect is applied first, the instruction at that destination issues, and then `fetch_pc` moves to the slot transfer's own destination.
- R11: A branch that is not taken does not redirect. The next `fetch_pc` is the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_en | input | 1 | The instruction at `fetch_pc` issues this cycle |
| br_kind | input | 4 | Decoded transfer kind (codes in R2 to R7) |
| src_a | input | 32 | First source operand; jump-register destination |
| src_b | input | 32 | Second source operand for the equality tests |
| br_off | input | 16 | Signed word displacement of a branch |
| jmp_field | input | 26 | Word index of a region jump |
| fetch_pc | output | 32 | Address of the instruction to issue |
| taken | output | 1 | The issuing instruction transfers control |
| link_we | output | 1 | Write `link_val` into register 31 |
| link_val | output | 32 | Return address, past the delay slot |

## Verification
Two functions can fall in the same cycle: a held redirect is applied while the delay-slot instruction that triggers it resolves a transfer of its own. Directed sequences place a jump-with-link in the slot of a jump. The random phase also produces transfer kinds back to back with a high probability of being taken. A reference model in the bench keeps its own pending state, and it judges each cycle by checking that the first destination is fetched, that the instruction there issues, and that only then does the second destination appear. Stalls placed between a transfer and its slot check that a held redirect survives idle cycles.

// File: rtl/branch_pc_pkg.sv
package branch_pc_pkg;

   typedef enum logic [3:0] {
      BK_NONE      = 4'd0,
      BK_EQ        = 4'd1,
      BK_NE        = 4'd2,
      BK_LEZ       = 4'd3,
      BK_GTZ       = 4'd4,
      BK_LTZ       = 4'd5,
      BK_GEZ       = 4'd6,
      BK_LTZ_LINK  = 4'd7,
      BK_GEZ_LINK  = 4'd8,
      BK_JUMP      = 4'd9,
      BK_JUMP_LINK = 4'd10,
      BK_JUMP_REG  = 4'd11
   } br_kind_e;

   function automatic logic kind_links(input br_kind_e k);
      return (k == BK_LTZ_LINK) || (k == BK_GEZ_LINK) || (k == BK_JUMP_LINK);
   endfunction

endpackage

// File: rtl/branch_pc_cond.sv
module branch_pc_cond
   import branch_pc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  br_kind_e          kind,
   input  logic [XLEN-1:0]   opa,
   input  logic [XLEN-1:0]   opb,
   output logic              take
);
   logic neg, zero, same;

   assign neg  = opa[XLEN-1];
   assign zero = (opa == '0);
   assign same = (opa == opb);

   always_comb begin
      case (kind)
         BK_EQ:                    take = same;
         BK_NE:                    take = !same;
         BK_LEZ:                   take = neg || zero;
         BK_GTZ:                   take = !neg && !zero;
         BK_LTZ, BK_LTZ_LINK:      take = neg;
         BK_GEZ, BK_GEZ_LINK:      take = !neg;
         BK_JUMP, BK_JUMP_LINK,
         BK_JUMP_REG:              take = 1'b1;
         default:                  take = 1'b0;
      endcase
   end
endmodule

// File: rtl/branch_pc_target.sv
module branch_pc_target
   import branch_pc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int JT_W  = 26,
   parameter int SHIFT = 2
) (
   input  br_kind_e          kind,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   opa,
   input  logic [OFF_W-1:0]  off,
   input  logic [JT_W-1:0]   jfield,
   output logic [XLEN-1:0]   dest
);
   localparam int REG_W = XLEN - JT_W - SHIFT;

   logic [XLEN-1:0] slot_pc, off_ext, rel_dest, reg_jump;

   assign slot_pc  = pc + XLEN'(1 << SHIFT);
   assign off_ext  = {{(XLEN-OFF_W){off[OFF_W-1]}}, off} << SHIFT;
   assign rel_dest = slot_pc + off_ext;

   generate
      if (REG_W > 0) begin : g_region
         assign reg_jump = {slot_pc[XLEN-1 -: REG_W], jfield, {SHIFT{1'b0}}};
      end else begin : g_flat
         assign reg_jump = {jfield, {SHIFT{1'b0}}};
      end
   endgenerate

   always_comb begin
      case (kind)
         BK_JUMP, BK_JUMP_LINK: dest = reg_jump;
         BK_JUMP_REG:           dest = opa;
         default:               dest = rel_dest;
      endcase
   end
endmodule

// File: rtl/branch_pc_seq.sv
module branch_pc_seq #(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter int              STEP     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              take,
   input  logic [XLEN-1:0]   dest,
   output logic [XLEN-1:0]   pc_q,
   output logic              pend_q,
   output logic [XLEN-1:0]   pend_dest_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q        <= RESET_PC;
         pend_q      <= 1'b0;
         pend_dest_q <= '0;
      end else if (adv) begin
         pc_q   <= pend_q ? pend_dest_q : pc_q + XLEN'(STEP);
         pend_q <= take;
         if (take) pend_dest_q <= dest;
      end
   end
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
   import branch_pc_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          OFF_W      = 16,
   parameter int          JT_W       = 26,
   parameter int          INSN_BYTES = 4,
   parameter logic [31:0] RESET_PC   = 32'h0000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_en,
   input  logic [3:0]        br_kind,
   input  logic [XLEN-1:0]   src_a,
   input  logic [XLEN-1:0]   src_b,
   input  logic [OFF_W-1:0]  br_off,
   input  logic [JT_W-1:0]   jmp_field,
   output logic [XLEN-1:0]   fetch_pc,
   output logic              taken,
   output logic              link_we,
   output logic [XLEN-1:0]   link_val
);
   localparam int SHIFT = $clog2(INSN_BYTES);

   generate
      if (INSN_BYTES < 1 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_step
         $error("INSN_BYTES must be a power of two");
      end
      if (JT_W + SHIFT > XLEN) begin : g_bad_jfield
         $error("jump field plus alignment exceeds XLEN");
      end
      if (OFF_W + SHIFT > XLEN || OFF_W < 2) begin : g_bad_off
         $error("branch displacement width out of range");
      end
   endgenerate

   br_kind_e          kind_e;
   logic              take_w, pend_w;
   logic [XLEN-1:0]   dest_w, pend_dest_w;

   assign kind_e = br_kind_e'(br_kind);

   branch_pc_cond #(.XLEN(XLEN)) u_cond (
      .kind (kind_e),
      .opa  (src_a),
      .opb  (src_b),
      .take (take_w)
   );

   branch_pc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W), .SHIFT(SHIFT)) u_target (
      .kind   (kind_e),
      .pc     (fetch_pc),
      .opa    (src_a),
      .off    (br_off),
      .jfield (jmp_field),
      .dest   (dest_w)
   );

   branch_pc_seq #(.XLEN(XLEN), .RESET_PC(XLEN'(RESET_PC)), .STEP(INSN_BYTES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv         (issue_en),
      .take        (taken),
      .dest        (dest_w),
      .pc_q        (fetch_pc),
      .pend_q      (pend_w),
      .pend_dest_q (pend_dest_w)
   );

   assign taken    = rst_n && issue_en && take_w;
   assign link_we  = rst_n && issue_en && kind_links(kind_e);
   assign link_val = fetch_pc + XLEN'(2 * INSN_BYTES);
endmodule

// File: rtl/branch_pc_chk.sv
module branch_pc_chk #(
   parameter int XLEN = 32,
   parameter int STEP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_en,
   input logic [3:0]        br_kind,
   input logic [XLEN-1:0]   fetch_pc,
   input logic              taken,
   input logic              link_we,
   input logic [XLEN-1:0]   link_val,
   input logic              pend,
   input logic [XLEN-1:0]   pend_dest
);
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_en |-> (!taken && !link_we));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_en |=> ($stable(fetch_pc) && $stable(pend)));

   a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_en && !pend && !taken) |=> (fetch_pc == $past(fetch_pc) + XLEN'(STEP)));

   a_r8_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_en && !pend && taken) |=> (pend && fetch_pc == $past(fetch_pc) + XLEN'(STEP)));

   a_r8_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_en && pend) |=> (fetch_pc == $past(pend_dest)));

   a_r6_jump_always: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_en && (br_kind == 4'd9 || br_kind == 4'd10 || br_kind == 4'd11)) |-> taken);

   a_r7_link: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_en && (br_kind == 4'd7 || br_kind == 4'd8 || br_kind == 4'd10))
         |-> (link_we && link_val == fetch_pc + XLEN'(2 * STEP)));
endmodule

bind branch_pc_unit branch_pc_chk #(.XLEN(XLEN), .STEP(INSN_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue_en  (issue_en),
   .br_kind   (br_kind),
   .fetch_pc  (fetch_pc),
   .taken     (taken),
   .link_we   (link_we),
   .link_val  (link_val),
   .pend      (pend_w),
   .pend_dest (pend_dest_w)
);

// File: tb/branch_pc_unit_bench.sv
module branch_pc_unit_bench;
   localparam logic [31:0] RST_PC = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_en = 1'b0;
   logic [3:0]  br_kind = 4'd0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [15:0] br_off = '0;
   logic [25:0] jmp_field = '0;
   logic [31:0] fetch_pc, link_val;
   logic        taken, link_we;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   logic [31:0] m_pc;
   logic        m_pend;
   logic [31:0] m_dest;
   string       m_dtag, m_ftag;

   always #10 clk = ~clk;

   branch_pc_unit u_branch_pc_unit (
      .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .br_kind(br_kind),
      .src_a(src_a), .src_b(src_b), .br_off(br_off), .jmp_field(jmp_field),
      .fetch_pc(fetch_pc), .taken(taken), .link_we(link_we), .link_val(link_val)
   );

   function automatic logic exp_take(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
      case (k)
         4'd1: return a == b;
         4'd2: return a != b;
         4'd3: return $signed(a) <= 0;
         4'd4: return $signed(a) > 0;
         4'd5, 4'd7: return $signed(a) < 0;
         4'd6, 4'd8: return $signed(a) >= 0;
         4'd9, 4'd10, 4'd11: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_dest(input logic [3:0] k, input logic [31:0] pc,
                                            input logic [31:0] a, input logic [15:0] o,
                                            input logic [25:0] j);
      logic [31:0] nxt;
      nxt = pc + 32'd4;
      if (k == 4'd9 || k == 4'd10) return {nxt[31:28], j, 2'b00};
      if (k == 4'd11) return a;
      return nxt + ({{16{o[15]}}, o} * 32'd4);
   endfunction

   function automatic string kind_tag(input logic [3:0] k);
      if (k == 4'd1 || k == 4'd2) return "R3";
      if (k >= 4'd3 && k <= 4'd8) return "R4";
      if (k >= 4'd9 && k <= 4'd11) return "R6";
      return "R2";
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // Called just after a falling edge; returns after the next falling edge.
   task automatic issue(input logic a, input logic [3:0] k, input logic [31:0] ra,
                        input logic [31:0] rb, input logic [15:0] o, input logic [25:0] j,
                        input string note);
      logic et, el;
      logic [31:0] nxt;
      string ct;
      chk(m_ftag, fetch_pc, m_pc);
      issue_en = a; br_kind = k; src_a = ra; src_b = rb; br_off = o; jmp_field = j;
      #2;
      ct = (note != "") ? note : kind_tag(k);
      et = a && exp_take(k, ra, rb);
      el = a && (k == 4'd7 || k == 4'd8 || k == 4'd10);
      chk(ct, 32'(taken), 32'(et));
      chk((note != "") ? note : "R7", 32'(link_we), 32'(el));
      if (el) chk("R7", link_val, m_pc + 32'd8);
      if (!a) m_ftag = "R9";
      else begin
         if (m_pend) m_ftag = m_dtag;
         else if (et) m_ftag = "R8";
         else if (k >= 4'd1 && k <= 4'd8) m_ftag = "R11";
         else m_ftag = "R2";
         nxt = m_pend ? m_dest : m_pc + 32'd4;
         if (et) begin
            m_dest = exp_dest(k, m_pc, ra, o, j);
            m_dtag = (note != "") ? note : ((k >= 4'd9) ? "R6" : "R5");
         end
         m_pend = et;
         m_pc = nxt;
      end
      @(negedge clk);
   endtask

   task automatic nop();
      issue(1'b1, 4'd0, 32'd0, 32'd0, 16'd0, 26'd0, "");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      issue_en = 1'b1; br_kind = 4'd10; src_a = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R1", fetch_pc, RST_PC);
      chk("R1", 32'(taken), 32'd0);
      chk("R1", 32'(link_we), 32'd0);
      issue_en = 1'b0;
      rst_n = 1'b1;
      m_pc = RST_PC; m_pend = 1'b0; m_dest = '0; m_dtag = "R5"; m_ftag = "R1";

      nop(); nop();
      // equal compare taken, negative displacement
      issue(1'b1, 4'd1, 32'h55, 32'h55, 16'hFFFD, 26'd0, "");
      nop(); nop();
      // not-equal on equal operands: falls through
      issue(1'b1, 4'd2, 32'h7, 32'h7, 16'h0040, 26'd0, "R11");
      nop();
      // link form, not taken, still links
      issue(1'b1, 4'd7, 32'h1234, 32'd0, 16'h0010, 26'd0, "R7");
      nop();
      // stall between a transfer and its slot
      issue(1'b1, 4'd4, 32'd5, 32'd0, 16'h0020, 26'd0, "");
      issue(1'b0, 4'd9, 32'd0, 32'd0, 16'd0, 26'h3FF, "R9");
      issue(1'b0, 4'd0, 32'd0, 32'd0, 16'd0, 26'd0, "R9");
      nop(); nop();
      // register jump near a region boundary, then region jump across it
      issue(1'b1, 4'd11, 32'h0FFF_FFF8, 32'd0, 16'd0, 26'd0, "");
      nop(); nop();
      issue(1'b1, 4'd9, 32'd0, 32'd0, 16'd0, 26'h012_3456, "R6");
      nop(); nop();
      // transfer inside a delay slot
      issue(1'b1, 4'd9, 32'd0, 32'd0, 16'd0, 26'h000_0400, "R6");
      issue(1'b1, 4'd10, 32'd0, 32'd0, 16'd0, 26'h000_0800, "R10");
      nop(); nop(); nop();
      // zero and sign boundaries
      issue(1'b1, 4'd3, 32'd0, 32'd0, 16'h0004, 26'd0, "R4");
      nop(); nop();
      issue(1'b1, 4'd6, 32'h8000_0000, 32'd0, 16'h0004, 26'd0, "R4");
      nop();
      issue(1'b1, 4'd5, 32'h8000_0000, 32'd0, 16'h7FFF, 26'd0, "R5");
      nop(); nop();

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] ra, rb;
         int mode;
         mode = int'($urandom_range(0, 3));
         ra = $urandom;
         case (mode)
            0: rb = ra;
            1: begin ra = '0; rb = $urandom; end
            2: rb = $urandom;
            default: begin ra[31] = 1'b1; rb = ra; end
         endcase
         issue(($urandom_range(0, 9) != 0), 4'($urandom_range(0, 15)), ra, rb,
               16'($urandom), 26'($urandom), "");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule